// File: doc/BRIEF.md
# Load-Use Stall and Late-Redirect Flush Controller

This block supplies the hazard control signals for a five-stage in-order pipeline. Taken branches and jumps write the program counter while they sit in the memory stage. It looks at the instruction word in decode and at a small amount of execute-stage and memory-stage state. From these it produces the write enables for the program counter and the fetch/decode register. It also produces clear requests for the three stage registers that lie between fetch and memory.

A load-use hazard exists when a load in execute writes a register that the decode-stage instruction reads. When the controller sees one, it freezes the PC and the fetch/decode register for one cycle and clears the decode/execute register, which puts a bubble into execute. The format of the instruction, taken from its opcode, decides which source fields are compared. A store's data operand is never compared, because forwarding supplies it. When the memory-stage instruction redirects the PC, the controller clears the fetch/decode, decode/execute and execute/memory registers in the same cycle. A redirect always overrides a stall. The stage registers, the forwarding paths and the branch comparator sit outside the block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `ex_is_load` is 1, `ex_rd` is nonzero and equals a compared source field of `id_instr`, the block stalls. A stall drives `pc_we`=0, `ifid_we`=0 and `idex_flush`=1, with `ifid_flush`=0, `exmem_flush`=0 and `pc_take_target`=0.
- R2: Source fields are rs1 = `id_instr[19:15]` and rs2 = `id_instr[24:20]`, with the opcode in `id_instr[6:0]`. Both fields are compared for register-register (0110011) and conditional-branch (1100011) opcodes. Only rs1 is compared for immediate-ALU (0010011), load (0000011), store (0100011) and jalr (1100111).
- R3: Upper-immediate (0110111, 0010111), jal (1101111) and all other opcodes compare no field and never stall.
- R4: A load whose `ex_rd` is 0 never causes a stall.
- R5: With `ex_is_load` at 0, no stall occurs, whatever the register fields hold.
- R6: A redirect is `mem_is_branch & mem_br_taken`, or `mem_is_jal`, or `mem_is_jalr`. In a redirect cycle `ifid_flush`, `idex_flush`, `exmem_flush`, `pc_take_target` and `pc_we` are all 1. A branch that is not taken causes no flush.
- R7: When a redirect and a load-use hazard occur in the same cycle, only the redirect takes effect: `pc_we`=1 and `ifid_we`=1.
- R8: A stall lasts exactly one cycle. In the cycle after a stall, no stall is raised, whatever the inputs hold.
- R9: With no hazard and no redirect, `pc_we`=1 and `ifid_we`=1, and all flush outputs and `pc_take_target` are 0. While `rst_n` is low, the one-cycle stall history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_instr | input | 32 | Instruction word in the decode stage |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_rd | input | 5 | Destination register of the execute-stage instruction |
| mem_is_branch | input | 1 | Memory-stage instruction is a conditional branch |
| mem_br_taken | input | 1 | Branch comparison result for the memory-stage branch |
| mem_is_jal | input | 1 | Memory-stage instruction is jal |
| mem_is_jalr | input | 1 | Memory-stage instruction is jalr |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| idex_flush | output | 1 | Clear the decode/execute register (bubble) |
| exmem_flush | output | 1 | Clear the execute/memory register |
| pc_take_target | output | 1 | Select the redirect target as next PC |

## Verification
Several properties are checked on every cycle. A frozen fetch/decode register always comes with a bubble and a held PC. A redirect always clears all three registers and lets the PC load. No stall is ever raised for x0, for a non-load, or for an upper-immediate or jal opcode. A freeze is never followed by a second freeze. Only the bench's scenarios can show which fields each opcode compares: for example, that a store matching only on rs2 does not stall while a branch matching on rs2 does. The scenarios also show that a redirect overrides a hazard, and that reset clears the stall history.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int INSTR_W = 32;
  localparam int REG_AW  = 5;
  localparam int OPC_W   = 7;
  localparam int NSRC    = 2;
  localparam int RS1_LSB = 15;
  localparam int RS2_LSB = 20;

  typedef logic [OPC_W-1:0] opcode_t;

  localparam opcode_t OPC_REGREG = 7'b0110011;
  localparam opcode_t OPC_IMMALU = 7'b0010011;
  localparam opcode_t OPC_LOAD   = 7'b0000011;
  localparam opcode_t OPC_STORE  = 7'b0100011;
  localparam opcode_t OPC_BRANCH = 7'b1100011;
  localparam opcode_t OPC_JALR   = 7'b1100111;
  localparam opcode_t OPC_JAL    = 7'b1101111;
  localparam opcode_t OPC_LUI    = 7'b0110111;
  localparam opcode_t OPC_AUIPC  = 7'b0010111;

  typedef struct packed {
    logic cmp_b;
    logic cmp_a;
  } src_use_t;

  // Which source fields a format exposes to a load-use hazard.
  // A store's data field (rs2) is excluded: forwarding serves it.
  function automatic src_use_t src_use(input opcode_t op);
    src_use_t u;
    u = '0;
    case (op)
      OPC_REGREG, OPC_BRANCH: begin
        u.cmp_a = 1'b1;
        u.cmp_b = 1'b1;
      end
      OPC_IMMALU, OPC_LOAD, OPC_STORE, OPC_JALR: u.cmp_a = 1'b1;
      default: u = '0;
    endcase
    return u;
  endfunction

  function automatic logic no_source_fmt(input opcode_t op);
    return (op == OPC_LUI) || (op == OPC_AUIPC) || (op == OPC_JAL);
  endfunction

  function automatic logic redirect_of(input logic br, input logic taken,
                                       input logic jal, input logic jalr);
    return (br & taken) | jal | jalr;
  endfunction

endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
  import hz_pkg::*;
#(
  parameter int IW  = INSTR_W,
  parameter int AW  = REG_AW,
  parameter int NS  = NSRC
) (
  input  logic [IW-1:0]        instr,
  output logic [NS-1:0][AW-1:0] src_idx,
  output logic [NS-1:0]         src_cmp
);

  localparam int LSB_A = RS1_LSB;
  localparam int LSB_B = RS2_LSB;

  opcode_t  opc;
  src_use_t use_f;
  logic     unused_fields;

  assign opc   = instr[OPC_W-1:0];
  assign use_f = src_use(opc);

  assign src_idx[0] = instr[LSB_A +: AW];
  assign src_cmp[0] = use_f.cmp_a;

  generate
    if (NS > 1) begin : g_second
      assign src_idx[1] = instr[LSB_B +: AW];
      assign src_cmp[1] = use_f.cmp_b;
    end
  endgenerate

  assign unused_fields = ^{instr[IW-1:LSB_B+AW], instr[LSB_A-1:OPC_W]};

endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect
  import hz_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int NS = NSRC
) (
  input  logic                  ex_is_load,
  input  logic [AW-1:0]         ex_rd,
  input  logic [NS-1:0][AW-1:0] src_idx,
  input  logic [NS-1:0]         src_cmp,
  output logic [NS-1:0]         src_match,
  output logic                  hazard
);

  logic rd_live;
  assign rd_live = |ex_rd;

  generate
    for (genvar i = 0; i < NS; i++) begin : g_cmp
      assign src_match[i] = src_cmp[i] & (src_idx[i] == ex_rd);
    end
  endgenerate

  assign hazard = ex_is_load & rd_live & (|src_match);

endmodule

// File: rtl/hz_redirect.sv
module hz_redirect
  import hz_pkg::*;
(
  input  logic mem_is_branch,
  input  logic mem_br_taken,
  input  logic mem_is_jal,
  input  logic mem_is_jalr,
  output logic redirect
);

  assign redirect = redirect_of(mem_is_branch, mem_br_taken, mem_is_jal, mem_is_jalr);

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int IW = INSTR_W,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] id_instr,
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_rd,
  input  logic          mem_is_branch,
  input  logic          mem_br_taken,
  input  logic          mem_is_jal,
  input  logic          mem_is_jalr,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ifid_flush,
  output logic          idex_flush,
  output logic          exmem_flush,
  output logic          pc_take_target
);

  logic [NSRC-1:0][AW-1:0] src_idx;
  logic [NSRC-1:0]         src_cmp;
  logic [NSRC-1:0]         src_match;
  logic                    hazard;
  logic                    redirect;
  logic                    stall;
  logic                    stall_q;

  hz_src_decode #(.IW(IW), .AW(AW), .NS(NSRC)) u_dec (
    .instr   (id_instr),
    .src_idx (src_idx),
    .src_cmp (src_cmp)
  );

  hz_loaduse_detect #(.AW(AW), .NS(NSRC)) u_det (
    .ex_is_load (ex_is_load),
    .ex_rd      (ex_rd),
    .src_idx    (src_idx),
    .src_cmp    (src_cmp),
    .src_match  (src_match),
    .hazard     (hazard)
  );

  hz_redirect u_redir (
    .mem_is_branch (mem_is_branch),
    .mem_br_taken  (mem_br_taken),
    .mem_is_jal    (mem_is_jal),
    .mem_is_jalr   (mem_is_jalr),
    .redirect      (redirect)
  );

  // Redirect wins; a cycle just after a stall holds the bubble in execute.
  assign stall = hazard & ~redirect & ~stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  assign pc_we          = ~stall;
  assign ifid_we        = ~stall;
  assign ifid_flush     = redirect;
  assign idex_flush     = redirect | stall;
  assign exmem_flush    = redirect;
  assign pc_take_target = redirect;

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [OPC_W-1:0] id_opcode,
  input logic          ex_is_load,
  input logic [AW-1:0] ex_rd,
  input logic          mem_is_branch,
  input logic          mem_br_taken,
  input logic          mem_is_jal,
  input logic          mem_is_jalr,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          ifid_flush,
  input logic          idex_flush,
  input logic          exmem_flush,
  input logic          pc_take_target
);

  logic redir_in;
  assign redir_in = (mem_is_branch & mem_br_taken) | mem_is_jal | mem_is_jalr;

  AST_FREEZE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |-> (!pc_we && idex_flush && !ifid_flush && !exmem_flush)); // R1
  AST_NOSRC_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    ((id_opcode == OPC_LUI) || (id_opcode == OPC_AUIPC) || (id_opcode == OPC_JAL)) |-> ifid_we); // R3
  AST_X0_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> ifid_we); // R4
  AST_NONLOAD_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> ifid_we); // R5
  AST_REDIRECT_FLUSH3: assert property (@(posedge clk) disable iff (!rst_n)
    redir_in |-> (ifid_flush && idex_flush && exmem_flush && pc_take_target && pc_we)); // R6
  AST_NO_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_in |-> (!ifid_flush && !exmem_flush && !pc_take_target)); // R6
  AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    redir_in |-> ifid_we); // R7
  AST_ONE_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !ifid_we |=> ifid_we); // R8

endmodule

bind pipe_hazard_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .id_opcode      (id_instr[hz_pkg::OPC_W-1:0]),
  .ex_is_load     (ex_is_load),
  .ex_rd          (ex_rd),
  .mem_is_branch  (mem_is_branch),
  .mem_br_taken   (mem_br_taken),
  .mem_is_jal     (mem_is_jal),
  .mem_is_jalr    (mem_is_jalr),
  .pc_we          (pc_we),
  .ifid_we        (ifid_we),
  .ifid_flush     (ifid_flush),
  .idex_flush     (idex_flush),
  .exmem_flush    (exmem_flush),
  .pc_take_target (pc_take_target)
);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] id_instr;
  logic        ex_is_load;
  logic [4:0]  ex_rd;
  logic        mem_is_branch, mem_br_taken, mem_is_jal, mem_is_jalr;
  logic        pc_we, ifid_we, ifid_flush, idex_flush, exmem_flush, pc_take_target;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit model_prev_stall = 0;
  logic rst_drv = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_hazard_ctrl u_pipe_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .id_instr(id_instr),
    .ex_is_load(ex_is_load), .ex_rd(ex_rd),
    .mem_is_branch(mem_is_branch), .mem_br_taken(mem_br_taken),
    .mem_is_jal(mem_is_jal), .mem_is_jalr(mem_is_jalr),
    .pc_we(pc_we), .ifid_we(ifid_we), .ifid_flush(ifid_flush),
    .idex_flush(idex_flush), .exmem_flush(exmem_flush),
    .pc_take_target(pc_take_target)
  );

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] a, input logic [4:0] b);
    return {7'b0101010, b, a, 3'b010, 5'd9, op};
  endfunction

  // One vector: drive at the falling edge, compare mid-low-phase, advance the model at the rising edge.
  task automatic apply(input logic [31:0] ins, input logic ld, input logic [4:0] rd,
                       input logic br, input logic tk, input logic jl, input logic jr,
                       input string tag);
    logic [6:0] op;
    logic [4:0] f1, f2;
    bit uses1, uses2, redir, hz, stl;
    logic [5:0] got, exp;
    @(negedge clk);
    rst_n = rst_drv;
    id_instr = ins; ex_is_load = ld; ex_rd = rd;
    mem_is_branch = br; mem_br_taken = tk; mem_is_jal = jl; mem_is_jalr = jr;
    #1;
    op = ins[6:0]; f1 = ins[19:15]; f2 = ins[24:20];
    uses1 = (op == 7'b0110011) || (op == 7'b1100011) || (op == 7'b0010011) ||
            (op == 7'b0000011) || (op == 7'b0100011) || (op == 7'b1100111);
    uses2 = (op == 7'b0110011) || (op == 7'b1100011);
    redir = (br && tk) || jl || jr;
    hz = ld && (rd != 0) && ((uses1 && f1 == rd) || (uses2 && f2 == rd));
    stl = hz && !redir && !model_prev_stall;
    exp = {!stl, !stl, redir, redir || stl, redir, redir};
    got = {pc_we, ifid_we, ifid_flush, idex_flush, exmem_flush, pc_take_target};
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: {pc_we,ifid_we,ifid_fl,idex_fl,exmem_fl,take} got %b expected %b", tag, got, exp);
    end
    @(posedge clk);
    model_prev_stall = rst_n ? stl : 1'b0;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    // R9: reset and idle
    rst_drv = 1'b0;
    apply(mk(7'b0010011, 5'd5, 5'd0), 1'b1, 5'd5, 0, 0, 0, 0, "R9 reset clears history");
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b0, 5'd0, 0, 0, 0, 0, "R9 idle in reset");
    rst_drv = 1'b1;
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b1, 5'd7, 0, 0, 0, 0, "R9 no hazard");
    // R1 / R8
    apply(mk(7'b0010011, 5'd5, 5'd0), 1'b1, 5'd5, 0, 0, 0, 0, "R1 addi rs1 after load");
    apply(mk(7'b0010011, 5'd5, 5'd0), 1'b1, 5'd5, 0, 0, 0, 0, "R8 no second stall");
    apply(mk(7'b0010011, 5'd5, 5'd0), 1'b1, 5'd5, 0, 0, 0, 0, "R1 stall again after gap");
    apply(mk(7'b0110011, 5'd3, 5'd4), 1'b0, 5'd0, 0, 0, 0, 0, "R9 recover");
    // R2
    apply(mk(7'b0110011, 5'd3, 5'd12), 1'b1, 5'd12, 0, 0, 0, 0, "R2 reg-reg rs2 match");
    apply(mk(7'b0110011, 5'd3, 5'd4), 1'b0, 5'd0, 0, 0, 0, 0, "R9 gap");
    apply(mk(7'b0100011, 5'd3, 5'd12), 1'b1, 5'd12, 0, 0, 0, 0, "R2 store data rs2 no stall");
    apply(mk(7'b0100011, 5'd12, 5'd3), 1'b1, 5'd12, 0, 0, 0, 0, "R2 store base rs1 stall");
    apply(mk(7'b0110011, 5'd3, 5'd4), 1'b0, 5'd0, 0, 0, 0, 0, "R9 gap");
    apply(mk(7'b1100011, 5'd1, 5'd20), 1'b1, 5'd20, 0, 0, 0, 0, "R2 branch rs2 stall");
    apply(mk(7'b0110011, 5'd3, 5'd4), 1'b0, 5'd0, 0, 0, 0, 0, "R9 gap");
    apply(mk(7'b0010011, 5'd1, 5'd20), 1'b1, 5'd20, 0, 0, 0, 0, "R2 immalu rs2 field ignored");
    apply(mk(7'b0000011, 5'd1, 5'd20), 1'b1, 5'd20, 0, 0, 0, 0, "R2 load rs2 field ignored");
    apply(mk(7'b1100111, 5'd20, 5'd2), 1'b1, 5'd20, 0, 0, 0, 0, "R2 jalr rs1 stall");
    apply(mk(7'b0110011, 5'd3, 5'd4), 1'b0, 5'd0, 0, 0, 0, 0, "R9 gap");
    // R3
    apply(mk(7'b0110111, 5'd8, 5'd8), 1'b1, 5'd8, 0, 0, 0, 0, "R3 lui");
    apply(mk(7'b0010111, 5'd8, 5'd8), 1'b1, 5'd8, 0, 0, 0, 0, "R3 auipc");
    apply(mk(7'b1101111, 5'd8, 5'd8), 1'b1, 5'd8, 0, 0, 0, 0, "R3 jal");
    apply(mk(7'b1110011, 5'd8, 5'd8), 1'b1, 5'd8, 0, 0, 0, 0, "R3 other opcode");
    // R4, R5
    apply(mk(7'b0110011, 5'd0, 5'd0), 1'b1, 5'd0, 0, 0, 0, 0, "R4 x0 destination");
    apply(mk(7'b0110011, 5'd9, 5'd9), 1'b0, 5'd9, 0, 0, 0, 0, "R5 non-load match");
    // R6
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b0, 5'd0, 1, 1, 0, 0, "R6 taken branch");
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b0, 5'd0, 1, 0, 0, 0, "R6 not-taken branch");
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b0, 5'd0, 0, 1, 0, 0, "R6 taken flag without branch");
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b0, 5'd0, 0, 0, 1, 0, "R6 jal");
    apply(mk(7'b0110011, 5'd1, 5'd2), 1'b0, 5'd0, 0, 0, 0, 1, "R6 jalr");
    // R7
    apply(mk(7'b0110011, 5'd6, 5'd2), 1'b1, 5'd6, 1, 1, 0, 0, "R7 hazard with taken branch");
    apply(mk(7'b0110011, 5'd6, 5'd2), 1'b1, 5'd6, 0, 0, 1, 0, "R7 hazard with jal");
    apply(mk(7'b0110011, 5'd6, 5'd2), 1'b1, 5'd6, 0, 0, 0, 0, "R1 stall after redirect");
    // mid-run reset clears stall history (R9)
    rst_drv = 1'b0;
    apply(mk(7'b0110011, 5'd6, 5'd2), 1'b1, 5'd6, 0, 0, 0, 0, "R9 stall in reset");
    rst_drv = 1'b1;
    apply(mk(7'b0110011, 5'd6, 5'd2), 1'b1, 5'd6, 0, 0, 0, 0, "R9 history cleared");
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] ops [9];
      logic [6:0] o;
      logic [4:0] a, b, d;
      ops = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b1100011,
              7'b1100111, 7'b1101111, 7'b0110111, 7'b0010111};
      o = ops[$urandom_range(0, 8)];
      a = 5'($urandom_range(0, 3));
      b = 5'($urandom_range(0, 3));
      d = 5'($urandom_range(0, 3));
      apply(mk(o, a, b), 1'($urandom_range(0, 1)), d,
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 7) == 0),
            "mixed R1 R2 R7 R8");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule